// File: doc/BRIEF.md
# Load-Store Address Generation Unit

This block forms the memory address for a load or store in a register-operand datapath. It also forms the value that goes back into the base register when the addressing form asks for an update. The base comes either from a register or from the program counter. The offset is either a 12-bit immediate or a register value passed through a logical shifter. A select line decides whether that offset is added to or subtracted from the base. All arithmetic is 32-bit and wraps modulo 2^32.

A two-bit indexing mode chooses among three forms:

- **Offset-first:** the address is base plus or minus offset, and the base is left unchanged.
- **Offset-first with update:** the same address is formed, and that sum is also written back as the new base.
- **Update-after:** the address is the untouched base, and the sum becomes the new base.

When the PC-relative flag is set, the base is the current instruction address plus 8. In that case the immediate is always the offset, no update happens, and the mode input is ignored.

The address logic is combinational. By default it is followed by one output register that clears on a synchronous, active-high reset. The register file, the memory port and the instruction decoder sit outside this block.

Top module: `ldst_agu_top`

## Requirements
- R1: With `idx_mode` = 2'b00 and `pc_rel` = 0, `eff_addr` = base ± offset, `base_next` = `base_val` and `wb_en` = 0.
- R2: With `idx_mode` = 2'b01 and `pc_rel` = 0, `eff_addr` = base ± offset, `base_next` equals that same `eff_addr`, and `wb_en` = 1.
- R3: With `idx_mode` = 2'b10 and `pc_rel` = 0, `eff_addr` = `base_val`, `base_next` = base ± offset, and `wb_en` = 1.
- R4: With `off_from_reg` = 1, the offset is `reg_off` shifted by `shift_amt` (5 bits, unsigned). The shift is logical left when `shift_right` = 0 and logical right when `shift_right` = 1.
- R5: With `off_from_reg` = 1 and `shift_amt` = 0, `reg_off` is used unchanged for both shift directions.
- R6: With `off_from_reg` = 0, the offset is `imm_off` zero-extended from 12 bits. `off_sub` = 1 subtracts the offset from the base and `off_sub` = 0 adds it; this select applies to both the immediate and the register offset.
- R7: With `pc_rel` = 1, the base is `instr_addr` + 8 and the offset is the immediate, whatever `off_from_reg` holds. `eff_addr` = base ± immediate, `base_next` = `instr_addr` + 8, and `wb_en` = 0 for every `idx_mode`.
- R8: A stack push (base 2012, immediate 4, `off_sub` = 1, `idx_mode` = 2'b01) gives `eff_addr` = 2008 and `base_next` = 2008 with `wb_en` = 1.
- R9: `idx_mode` = 2'b11 is reserved and behaves exactly like 2'b00.
- R10: Address sums wrap modulo 2^32 in both directions. For example, 0xFFFFFFF0 + 0x20 = 0x00000010 and 0x4 − 0x10 = 0xFFFFFFF4.
- R11: With `OUT_REG` = 1, the outputs reflect the inputs one clock edge after they are applied. A reset held across an edge clears `eff_addr`, `base_next` and `wb_en` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Unsigned immediate offset magnitude |
| reg_off | input | 32 | Offset register value |
| off_from_reg | input | 1 | 1: offset from `reg_off`, 0: from `imm_off` |
| shift_right | input | 1 | Register offset shift direction, 1 = logical right |
| shift_amt | input | 5 | Register offset shift amount |
| off_sub | input | 1 | 1: subtract offset, 0: add |
| idx_mode | input | 2 | 00 offset-first, 01 offset-first with update, 10 update-after, 11 as 00 |
| pc_rel | input | 1 | Use instruction address + 8 as base |
| instr_addr | input | 32 | Address of the current instruction |
| eff_addr | output | 32 | Effective memory address |
| base_next | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register write strobe |

## Verification
The PC-relative override and the indexing mode can both be active in the same cycle. This happens when `pc_rel` is set together with an update mode and with a register offset selected. The bench provokes this both in directed vectors and in random traffic. The expectation is that the PC form wins outright: the strobe is low, the immediate is the offset even though a register offset was selected, and `base_next` reads back as the instruction address plus 8. A reset arriving in the same cycle as a fresh request is also driven, and its outcome is judged by all-zero outputs one edge later.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

    localparam int AGU_AW   = 32;
    localparam int AGU_IMMW = 12;
    localparam int AGU_SHW  = 5;
    localparam int AGU_PC_AHEAD = 8;

    typedef logic [AGU_AW-1:0] addr_t;

    typedef enum logic [1:0] {
        IDX_PRE    = 2'b00,
        IDX_PRE_WB = 2'b01,
        IDX_POST   = 2'b10,
        IDX_RSVD   = 2'b11
    } idx_mode_e;

    typedef struct packed {
        addr_t     eff;
        addr_t     base_nxt;
        logic      wb;
    } agu_resp_t;

    function automatic addr_t zext_imm(input logic [AGU_IMMW-1:0] imm);
        return addr_t'(imm);
    endfunction

    function automatic logic mode_updates(input idx_mode_e m);
        return (m == IDX_PRE_WB) || (m == IDX_POST);
    endfunction

    function automatic logic mode_addr_is_base(input idx_mode_e m);
        return (m == IDX_POST);
    endfunction

endpackage

// File: rtl/agu_offset_unit.sv
module agu_offset_unit
    import ldst_agu_pkg::*;
#(
    parameter int AW   = AGU_AW,
    parameter int IMMW = AGU_IMMW,
    parameter int SHW  = AGU_SHW
) (
    input  logic [AW-1:0]   reg_val,
    input  logic [IMMW-1:0] imm_val,
    input  logic            use_reg,
    input  logic            shr,
    input  logic [SHW-1:0]  amt,
    output logic [AW-1:0]   off_mag
);
    localparam int NSTG = SHW + 1;

    logic [AW-1:0] stg [NSTG];

    assign stg[0] = reg_val;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        always_comb begin
            if (!amt[s]) begin
                stg[s+1] = stg[s];
            end else if (shr) begin
                stg[s+1] = stg[s] >> DIST;
            end else begin
                stg[s+1] = stg[s] << DIST;
            end
        end
    end

    always_comb begin
        if (use_reg) begin
            off_mag = stg[SHW];
        end else begin
            off_mag = {{(AW-IMMW){1'b0}}, imm_val};
        end
    end

endmodule

// File: rtl/agu_addsub.sv
module agu_addsub
    import ldst_agu_pkg::*;
#(
    parameter int AW = AGU_AW
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] b_eff;

    always_comb begin
        b_eff = b ^ {AW{sub}};
        sum   = a + b_eff + {{(AW-1){1'b0}}, sub};
    end

endmodule

// File: rtl/agu_mode_ctrl.sv
module agu_mode_ctrl
    import ldst_agu_pkg::*;
(
    input  addr_t     base_op,
    input  addr_t     sum,
    input  idx_mode_e mode,
    input  logic      pc_rel,
    output agu_resp_t resp
);
    logic upd;
    logic use_base;

    always_comb begin
        upd      = mode_updates(mode) && !pc_rel;
        use_base = mode_addr_is_base(mode) && !pc_rel;
        resp.eff      = use_base ? base_op : sum;
        resp.base_nxt = upd ? sum : base_op;
        resp.wb       = upd;
    end

endmodule

// File: rtl/ldst_agu_top.sv
module ldst_agu_top
    import ldst_agu_pkg::*;
#(
    parameter int OUT_REG  = 1,
    parameter int PC_AHEAD = AGU_PC_AHEAD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AGU_AW-1:0]    base_val,
    input  logic [AGU_IMMW-1:0]  imm_off,
    input  logic [AGU_AW-1:0]    reg_off,
    input  logic                 off_from_reg,
    input  logic                 shift_right,
    input  logic [AGU_SHW-1:0]   shift_amt,
    input  logic                 off_sub,
    input  logic [1:0]           idx_mode,
    input  logic                 pc_rel,
    input  logic [AGU_AW-1:0]    instr_addr,
    output logic [AGU_AW-1:0]    eff_addr,
    output logic [AGU_AW-1:0]    base_next,
    output logic                 wb_en
);
    localparam addr_t PC_BIAS = addr_t'(PC_AHEAD);

    addr_t     base_op;
    addr_t     off_mag;
    addr_t     sum;
    idx_mode_e mode;
    agu_resp_t resp_d;
    agu_resp_t resp_q;

    always_comb begin
        mode    = idx_mode_e'(idx_mode);
        base_op = pc_rel ? (instr_addr + PC_BIAS) : base_val;
    end

    agu_offset_unit #(
        .AW   (AGU_AW),
        .IMMW (AGU_IMMW),
        .SHW  (AGU_SHW)
    ) u_off (
        .reg_val (reg_off),
        .imm_val (imm_off),
        .use_reg (off_from_reg && !pc_rel),
        .shr     (shift_right),
        .amt     (shift_amt),
        .off_mag (off_mag)
    );

    agu_addsub #(
        .AW (AGU_AW)
    ) u_add (
        .a   (base_op),
        .b   (off_mag),
        .sub (off_sub),
        .sum (sum)
    );

    agu_mode_ctrl u_mode (
        .base_op (base_op),
        .sum     (sum),
        .mode    (mode),
        .pc_rel  (pc_rel),
        .resp    (resp_d)
    );

    if (OUT_REG != 0) begin : g_oreg
        always_ff @(posedge clk) begin
            if (rst) begin
                resp_q <= '0;
            end else begin
                resp_q <= resp_d;
            end
        end
    end else begin : g_comb
        assign resp_q = resp_d;
    end

    assign eff_addr  = resp_q.eff;
    assign base_next = resp_q.base_nxt;
    assign wb_en     = resp_q.wb;

endmodule

// File: rtl/ldst_agu_sva.sv
module ldst_agu_sva
    import ldst_agu_pkg::*;
#(
    parameter int OUT_REG  = 1,
    parameter int PC_AHEAD = AGU_PC_AHEAD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AGU_AW-1:0]   base_val,
    input  logic [AGU_IMMW-1:0] imm_off,
    input  logic [AGU_AW-1:0]   reg_off,
    input  logic                off_from_reg,
    input  logic [AGU_SHW-1:0]  shift_amt,
    input  logic                off_sub,
    input  logic [1:0]          idx_mode,
    input  logic                pc_rel,
    input  logic [AGU_AW-1:0]   instr_addr,
    input  logic [AGU_AW-1:0]   eff_addr,
    input  logic [AGU_AW-1:0]   base_next,
    input  logic                wb_en
);
    logic [AGU_AW-1:0]   d_base, d_roff, d_ia;
    logic [AGU_IMMW-1:0] d_imm;
    logic                d_ureg, d_sub, d_pc, d_vld;
    logic [AGU_SHW-1:0]  d_amt;
    logic [1:0]          d_mode;

    if (OUT_REG != 0) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                d_vld <= 1'b0;
                d_base <= '0; d_roff <= '0; d_ia <= '0; d_imm <= '0;
                d_ureg <= 1'b0; d_sub <= 1'b0; d_pc <= 1'b0;
                d_amt <= '0; d_mode <= '0;
            end else begin
                d_vld <= 1'b1;
                d_base <= base_val; d_roff <= reg_off; d_ia <= instr_addr;
                d_imm <= imm_off; d_ureg <= off_from_reg; d_sub <= off_sub;
                d_pc <= pc_rel; d_amt <= shift_amt; d_mode <= idx_mode;
            end
        end
    end else begin : g_now
        assign d_vld = 1'b1;
        assign d_base = base_val; assign d_roff = reg_off; assign d_ia = instr_addr;
        assign d_imm = imm_off; assign d_ureg = off_from_reg; assign d_sub = off_sub;
        assign d_pc = pc_rel; assign d_amt = shift_amt; assign d_mode = idx_mode;
    end

    logic [AGU_AW-1:0] pc_base;
    assign pc_base = d_ia + AGU_AW'(PC_AHEAD);

    // R3: update-after addresses with the untouched base
    p_post_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (d_vld && !d_pc && d_mode == 2'b10) |-> (eff_addr == d_base && wb_en));

    // R2: writeback value equals the address used
    p_wb_same_r2: assert property (@(posedge clk) disable iff (rst)
        (d_vld && !d_pc && d_mode == 2'b01) |-> (base_next == eff_addr && wb_en));

    // R1 and R9: no strobe, base unchanged
    p_pre_keep_r1: assert property (@(posedge clk) disable iff (rst)
        (d_vld && !d_pc && d_mode[1] == d_mode[0]) |-> (!wb_en && base_next == d_base));

    // R7: PC-relative never writes back
    p_pc_nowb_r7: assert property (@(posedge clk) disable iff (rst)
        (d_vld && d_pc) |-> (!wb_en && base_next == pc_base));

    // R5: zero shift passes the register through
    p_shamt0_r5: assert property (@(posedge clk) disable iff (rst)
        (d_vld && !d_pc && d_ureg && d_amt == '0 && !d_sub && d_mode == 2'b00)
        |-> (eff_addr == d_base + d_roff));

    // R6: immediate subtraction from a register base
    p_imm_sub_r6: assert property (@(posedge clk) disable iff (rst)
        (d_vld && !d_pc && !d_ureg && d_sub && d_mode == 2'b01)
        |-> (eff_addr + {{(AGU_AW-AGU_IMMW){1'b0}}, d_imm} == d_base));

endmodule

bind ldst_agu_top ldst_agu_sva #(
    .OUT_REG  (OUT_REG),
    .PC_AHEAD (PC_AHEAD)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .base_val     (base_val),
    .imm_off      (imm_off),
    .reg_off      (reg_off),
    .off_from_reg (off_from_reg),
    .shift_amt    (shift_amt),
    .off_sub      (off_sub),
    .idx_mode     (idx_mode),
    .pc_rel       (pc_rel),
    .instr_addr   (instr_addr),
    .eff_addr     (eff_addr),
    .base_next    (base_next),
    .wb_en        (wb_en)
);

// File: tb/ldst_agu_top_tb.sv
module ldst_agu_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_val = '0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic        off_from_reg = 1'b0;
    logic        shift_right = 1'b0;
    logic [4:0]  shift_amt = '0;
    logic        off_sub = 1'b0;
    logic [1:0]  idx_mode = '0;
    logic        pc_rel = 1'b0;
    logic [31:0] instr_addr = '0;
    logic [31:0] eff_addr, base_next;
    logic        wb_en;

    int total = 0;
    int bad = 0;

    ldst_agu_top u_dut (
        .clk(clk), .rst(rst), .base_val(base_val), .imm_off(imm_off),
        .reg_off(reg_off), .off_from_reg(off_from_reg), .shift_right(shift_right),
        .shift_amt(shift_amt), .off_sub(off_sub), .idx_mode(idx_mode),
        .pc_rel(pc_rel), .instr_addr(instr_addr), .eff_addr(eff_addr),
        .base_next(base_next), .wb_en(wb_en)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [64:0] model();
        logic [31:0] b, off, s, e, nb;
        logic        w;
        logic [1:0]  m;
        b = pc_rel ? instr_addr + 32'd8 : base_val;
        if (off_from_reg && !pc_rel)
            off = shift_right ? (reg_off >> shift_amt) : (reg_off << shift_amt);
        else
            off = {20'd0, imm_off};
        s = off_sub ? b - off : b + off;
        m = pc_rel ? 2'b00 : idx_mode;
        case (m)
            2'b01:   begin e = s; nb = s; w = 1'b1; end
            2'b10:   begin e = b; nb = s; w = 1'b1; end
            default: begin e = s; nb = b; w = 1'b0; end
        endcase
        return {e, nb, w};
    endfunction

    task automatic compare(input string tag, input logic [64:0] exp);
        total++;
        if ({eff_addr, base_next, wb_en} !== exp) begin
            bad++;
            $display("FAIL %s: actual eff=%h nb=%h wb=%b expected eff=%h nb=%h wb=%b",
                     tag, eff_addr, base_next, wb_en, exp[64:33], exp[32:1], exp[0]);
        end
    endtask

    task automatic drive(input logic [31:0] b, input logic [11:0] im, input logic [31:0] ro,
                         input logic ur, input logic sr, input logic [4:0] sa,
                         input logic sb, input logic [1:0] md, input logic pc,
                         input logic [31:0] ia);
        @(negedge clk);
        base_val = b; imm_off = im; reg_off = ro; off_from_reg = ur;
        shift_right = sr; shift_amt = sa; off_sub = sb; idx_mode = md;
        pc_rel = pc; instr_addr = ia;
    endtask

    task automatic vec(input string tag);
        @(negedge clk);
        compare(tag, model());
    endtask

    initial begin
        logic [64:0] prev;
        void'($urandom(32'h00C0FFEE));
        // R11: reset clears outputs even with active inputs
        drive(32'h1234, 12'h10, 32'h0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b01, 1'b0, 32'h0);
        @(negedge clk);
        compare("R11 reset", 65'd0);
        rst = 1'b0;

        drive(32'd1000, 12'd200, 32'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        vec("R1 pre add");
        compare("R1 pre value", {32'd1200, 32'd1000, 1'b0});
        drive(32'd1000, 12'd0, 32'd200, 1'b1, 1'b0, 5'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        vec("R5 shamt0 left");
        drive(32'd1000, 12'd0, 32'h8000_0001, 1'b1, 1'b1, 5'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        vec("R5 shamt0 right");
        drive(32'd1000, 12'd0, 32'd25, 1'b1, 1'b0, 5'd2, 1'b0, 2'b10, 1'b0, 32'd0);
        vec("R3 post shifted");
        compare("R3 post value", {32'd1000, 32'd1100, 1'b1});
        drive(32'd1000, 12'd0, 32'hF000_0000, 1'b1, 1'b1, 5'd31, 1'b0, 2'b00, 1'b0, 32'd0);
        vec("R4 right 31");
        drive(32'd0, 12'd0, 32'h0000_0003, 1'b1, 1'b0, 5'd31, 1'b0, 2'b00, 1'b0, 32'd0);
        vec("R4 left 31");
        drive(32'd2012, 12'd4, 32'd0, 1'b0, 1'b0, 5'd0, 1'b1, 2'b01, 1'b0, 32'd0);
        vec("R8 push");
        compare("R8 push value", {32'd2008, 32'd2008, 1'b1});
        drive(32'd1200, 12'd0, 32'd200, 1'b1, 1'b0, 5'd0, 1'b1, 2'b01, 1'b0, 32'd0);
        vec("R2 reg sub wb");
        drive(32'd500, 12'd52, 32'd7, 1'b1, 1'b0, 5'd3, 1'b0, 2'b01, 1'b1, 32'd1000);
        vec("R7 pc with wb mode and reg sel");
        compare("R7 pc value", {32'd1060, 32'd1008, 1'b0});
        drive(32'd500, 12'd8, 32'd7, 1'b0, 1'b0, 5'd0, 1'b1, 2'b10, 1'b1, 32'd1000);
        vec("R7 pc sub post");
        drive(32'd700, 12'd9, 32'd0, 1'b0, 1'b0, 5'd0, 1'b1, 2'b11, 1'b0, 32'd0);
        vec("R9 reserved mode");
        compare("R9 reserved value", {32'd691, 32'd700, 1'b0});
        drive(32'hFFFF_FFF0, 12'h20, 32'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        vec("R10 wrap up");
        compare("R10 wrap up value", {32'h10, 32'hFFFF_FFF0, 1'b0});
        drive(32'h4, 12'h10, 32'd0, 1'b0, 1'b0, 5'd0, 1'b1, 2'b00, 1'b0, 32'd0);
        vec("R10 wrap down");
        compare("R6 imm sub value", {32'hFFFF_FFF4, 32'h4, 1'b0});

        // R11: outputs hold until the next edge after new inputs
        prev = model();
        drive(32'd77, 12'd3, 32'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b10, 1'b0, 32'd0);
        #1;
        compare("R11 latency hold", prev);
        vec("R11 latency update");

        for (int i = 0; i < 600; i++) begin
            drive($urandom, 12'($urandom), $urandom, 1'($urandom), 1'($urandom),
                  5'($urandom), 1'($urandom), 2'($urandom), (($urandom % 5) == 0),
                  $urandom);
            case ({pc_rel, idx_mode})
                3'b000:  vec("R1 random");
                3'b001:  vec("R2 random");
                3'b010:  vec("R3 random");
                3'b011:  vec("R9 random");
                default: vec("R7 random");
            endcase
        end

        // R11: reset in the same cycle as a new request
        drive(32'd5, 12'd5, 32'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b01, 1'b0, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        compare("R11 reset mid-run", 65'd0);
        rst = 1'b0;
        vec("R2 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule